// File: doc/BRIEF.md
# Trigger-Synchronized Clock Regenerator

This block runs entirely in one fast sampling clock domain. A slower reference clock arrives asynchronously. The block measures that reference's period and low-phase length in sampling ticks. It then rebuilds a copy of the reference whose phase restarts at every falling edge of an asynchronous trigger input. Horizontal-sync style phase control is the typical use: a line-start strobe drops, and after a fixed latency a clock with a known phase runs from that point.

From the rebuilt clock the block drives six outputs:

- a synchronized clock and its complement;
- a divide-by-two clock and its complement;
- a one-shot pulse, two reference periods long;
- a continuous clock that carries the raw reference while the trigger is high and the synchronized copy while the trigger is low.

Positive glitches on the trigger are filtered out. A trigger fall passes after synchronization only. An output-valid flag tells the system when the measurement has settled behind a long enough trigger-high interval.

Top module: `trig_clk_regen`

## Requirements
- R1: After the trigger input goes low, the first high level of `sync_clk` is seen on the (L+5)-th rising sampling edge. Edges are counted from the first edge that samples the trigger low, and L is the measured reference low width in ticks.
- R2: After reset, and while the filtered trigger is high, `sync_clk`, `div2_clk` and `pulse_out` are 0, and `sync_clk_n` and `div2_clk_n` are 1.
- R3: While running, `sync_clk` repeats every P ticks, where P is the measured reference period. In each period it is low for L ticks and high for P-L ticks. `sync_clk_n` is always the complement of `sync_clk`, and `div2_clk_n` is always the complement of `div2_clk`.
- R4: `div2_clk` is 0 at every trigger fall until the first `sync_clk` rise. It then toggles on every `sync_clk` rise, so it is high for P of every 2P ticks.
- R5: After a trigger fall, `pulse_out` goes high together with the first `sync_clk` rise. It stays high for exactly 2P ticks, then stays low until the next trigger fall.
- R6: While the filtered trigger is high, `cont_clk` carries the synchronized reference, three sampling cycles late. While it is low, `cont_clk` equals `sync_clk` on every cycle.
- R7: A trigger high lasting fewer than FILT_LEN sampled cycles is ignored: the running clock is not restarted and no pulse fires. A trigger low is taken after the two-flop synchronizer alone.
- R8: `out_valid` is 0 from reset until two reference rising edges have been measured and the filtered trigger has been high for HOLD_MIN+1 consecutive cycles. A new measured period that differs from the previous one by more than one tick clears it. A change in duty alone at the same period does not clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Asynchronous reference clock |
| trig_in | input | 1 | Asynchronous trigger; its fall restarts the phase |
| sync_clk | output | 1 | Regenerated clock aligned to the trigger fall |
| sync_clk_n | output | 1 | Complement of sync_clk |
| div2_clk | output | 1 | sync_clk divided by two |
| div2_clk_n | output | 1 | Complement of div2_clk |
| pulse_out | output | 1 | One-shot pulse, two reference periods long |
| cont_clk | output | 1 | Raw reference while trigger high, sync_clk while low |
| out_valid | output | 1 | Measurement settled after a long enough trigger high |

## Verification
The assertions take for granted that the reference has at least one high tick and one low tick per cycle, so the low width is always below the period. They also take for granted that a trigger fall can only follow a filtered trigger-high interval.

The stimulus changes the reference period or duty only while the trigger is held high. Each change takes effect at a reference rising edge, so no run sees a partial cycle. All edges of both the reference and the trigger are placed well clear of the sampling edge. Glitches are injected only while the regenerated clock is running, because that is where a false restart would show at the outputs.

// File: rtl/tcg_pkg.sv
package tcg_pkg;

  // Default sizing shared by the block and its bench
  localparam int unsigned TCG_CNT_W_DEF = 8;
  localparam int unsigned TCG_FILT_DEF  = 3;
  localparam int unsigned TCG_HOLD_DEF  = 16;

  // Registered output levels produced by the regenerator
  typedef struct packed {
    logic sync;
    logic div2;
    logic pulse;
    logic cont;
  } tcg_out_t;

endpackage

// File: rtl/tcg_sync2.sv
module tcg_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= d[i];
        stab_q <= meta_q;
      end
    end
    assign q[i] = stab_q;
  end

endmodule

// File: rtl/tcg_trig_filt.sv
module tcg_trig_filt #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_s,
  output logic trig_hi,
  output logic trig_fall
);

  localparam int unsigned HC_W = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);
  localparam logic [HC_W-1:0] LAST = HC_W'(FILT_LEN - 1);

  logic [HC_W-1:0] hcnt;
  logic            trig_d;

  // High must persist for FILT_LEN samples; low is accepted at once
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt    <= '0;
      trig_hi <= 1'b0;
      trig_d  <= 1'b0;
    end else begin
      trig_d <= trig_hi;
      if (!trig_s) begin
        hcnt    <= '0;
        trig_hi <= 1'b0;
      end else if (hcnt == LAST) begin
        trig_hi <= 1'b1;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  assign trig_fall = trig_d & ~trig_hi;

  // R7: acceptance of a high needs the synchronized input to be high
  a_r7_rise_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_hi) |-> $past(trig_s));

  // R7: a low on the synchronized input is passed on the next edge
  a_r7_fall_prompt: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trig_s) |=> !trig_hi);

endmodule

// File: rtl/tcg_ref_meas.sv
module tcg_ref_meas #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_s,
  output logic [CNT_W-1:0] per,
  output logic [CNT_W-1:0] low_w,
  output logic             meas_ok,
  output logic             per_chg
);

  logic             ref_d;
  logic             seen_rise;
  logic [CNT_W-1:0] cyc_cnt;
  logic [CNT_W-1:0] low_cnt;
  logic             ref_rise;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  function automatic logic far_apart(input logic [CNT_W-1:0] a,
                                     input logic [CNT_W-1:0] b);
    logic [CNT_W-1:0] diff;
    diff = (a > b) ? (a - b) : (b - a);
    return diff > CNT_W'(1);
  endfunction

  assign ref_rise = ref_s & ~ref_d;

  // Ticks between rising edges give the period; low samples give the low width
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_d     <= 1'b0;
      seen_rise <= 1'b0;
      cyc_cnt   <= '0;
      low_cnt   <= '0;
      per       <= '0;
      low_w     <= '0;
      meas_ok   <= 1'b0;
      per_chg   <= 1'b0;
    end else begin
      ref_d   <= ref_s;
      per_chg <= 1'b0;
      if (ref_rise) begin
        cyc_cnt   <= CNT_W'(1);
        low_cnt   <= '0;
        seen_rise <= 1'b1;
        if (seen_rise) begin
          per     <= cyc_cnt;
          low_w   <= low_cnt;
          meas_ok <= 1'b1;
          per_chg <= meas_ok && far_apart(cyc_cnt, per);
        end
      end else begin
        cyc_cnt <= sat_inc(cyc_cnt);
        if (!ref_s) low_cnt <= sat_inc(low_cnt);
      end
    end
  end

  // R3: a settled measurement always has a low phase shorter than the period
  a_r3_low_below_period: assert property (@(posedge clk) disable iff (!rst_n)
    meas_ok |-> (low_w < per));

endmodule

// File: rtl/tcg_regen.sv
module tcg_regen
  import tcg_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_hi,
  input  logic             trig_fall,
  input  logic             ref_s,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] low_w,
  output tcg_out_t         lvl
);

  localparam int unsigned EW = CNT_W + 2;

  logic             run;
  logic [CNT_W-1:0] phase;
  logic [CNT_W-1:0] run_per;
  logic [CNT_W-1:0] run_low;
  logic [EW-1:0]    elapsed;
  logic [EW-1:0]    plen;
  logic             sync_q, div_q, pulse_q, cont_q;
  logic             sync_nx;
  logic             sync_rise_nx;

  function automatic logic [CNT_W-1:0] next_phase(input logic [CNT_W-1:0] ph,
                                                  input logic [CNT_W-1:0] pr);
    return ((pr == '0) || (ph >= pr - 1'b1)) ? '0 : ph + 1'b1;
  endfunction

  function automatic logic [EW-1:0] el_inc(input logic [EW-1:0] e);
    return (&e) ? e : e + 1'b1;
  endfunction

  // Pulse spans two periods starting with the first high phase
  function automatic logic pulse_window(input logic [EW-1:0]    el,
                                        input logic [CNT_W-1:0] lo,
                                        input logic [CNT_W-1:0] pr);
    logic [EW-1:0] lo_x;
    logic [EW-1:0] two_p;
    lo_x  = {2'b00, lo};
    two_p = {1'b0, pr, 1'b0};
    return (el >= lo_x) && (el < lo_x + two_p);
  endfunction

  assign sync_nx      = (phase >= run_low);
  assign sync_rise_nx = sync_nx & ~sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      phase   <= '0;
      run_per <= '0;
      run_low <= '0;
      elapsed <= '0;
      sync_q  <= 1'b0;
      div_q   <= 1'b0;
      pulse_q <= 1'b0;
      cont_q  <= 1'b0;
    end else if (trig_hi) begin
      run     <= 1'b0;
      phase   <= '0;
      elapsed <= '0;
      sync_q  <= 1'b0;
      div_q   <= 1'b0;
      pulse_q <= 1'b0;
      cont_q  <= ref_s;
    end else if (trig_fall) begin
      run     <= 1'b1;
      phase   <= '0;
      elapsed <= '0;
      run_per <= per;
      run_low <= low_w;
      sync_q  <= 1'b0;
      div_q   <= 1'b0;
      pulse_q <= 1'b0;
      cont_q  <= 1'b0;
    end else if (run) begin
      phase   <= next_phase(phase, run_per);
      elapsed <= el_inc(elapsed);
      sync_q  <= sync_nx;
      cont_q  <= sync_nx;
      pulse_q <= pulse_window(elapsed, run_low, run_per);
      if (sync_rise_nx) div_q <= ~div_q;
    end else begin
      cont_q <= 1'b0;
    end
  end

  // Length of the current high run of the pulse, used by the checks below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) plen <= '0;
    else        plen <= pulse_q ? plen + 1'b1 : '0;
  end

  assign lvl.sync  = sync_q;
  assign lvl.div2  = div_q;
  assign lvl.pulse = pulse_q;
  assign lvl.cont  = cont_q;

  // R2: a high trigger silences the regenerated outputs on the next edge
  a_r2_quiet_when_high: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hi |=> (!sync_q && !div_q && !pulse_q));

  // R4: every rise of the regenerated clock flips the divided clock
  a_r4_div_follows_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $rose(sync_q)) |-> (div_q != $past(div_q)));

  // R5: a pulse that ends while running lasted two latched periods
  a_r5_pulse_two_periods: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pulse_q) && run) |-> (plen == {1'b0, run_per, 1'b0}));

  // R5: the pulse never starts before the clock's first high phase
  a_r5_pulse_with_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> sync_q);

endmodule

// File: rtl/trig_clk_regen.sv
module trig_clk_regen
  import tcg_pkg::*;
#(
  parameter int unsigned CNT_W    = TCG_CNT_W_DEF,
  parameter int unsigned FILT_LEN = TCG_FILT_DEF,
  parameter int unsigned HOLD_MIN = TCG_HOLD_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic trig_in,
  output logic sync_clk,
  output logic sync_clk_n,
  output logic div2_clk,
  output logic div2_clk_n,
  output logic pulse_out,
  output logic cont_clk,
  output logic out_valid
);

  localparam int unsigned HW = $clog2(HOLD_MIN + 1) < 1 ? 1 : $clog2(HOLD_MIN + 1);

  logic [1:0]       raw_in;
  logic [1:0]       syn_in;
  logic             ref_s, trig_s;
  logic             trig_hi, trig_fall;
  logic [CNT_W-1:0] per, low_w;
  logic             meas_ok, per_chg;
  tcg_out_t         lvl;
  logic [HW-1:0]    hold_cnt;

  assign raw_in = {ref_in, trig_in};
  assign ref_s  = syn_in[1];
  assign trig_s = syn_in[0];

  tcg_sync2 #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (syn_in)
  );

  tcg_trig_filt #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_s    (trig_s),
    .trig_hi   (trig_hi),
    .trig_fall (trig_fall)
  );

  tcg_ref_meas #(.CNT_W(CNT_W)) u_meas (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_s   (ref_s),
    .per     (per),
    .low_w   (low_w),
    .meas_ok (meas_ok),
    .per_chg (per_chg)
  );

  tcg_regen #(.CNT_W(CNT_W)) u_regen (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_hi   (trig_hi),
    .trig_fall (trig_fall),
    .ref_s     (ref_s),
    .per       (per),
    .low_w     (low_w),
    .lvl       (lvl)
  );

  // Valid after a long enough high trigger on a settled measurement
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt  <= '0;
      out_valid <= 1'b0;
    end else if (per_chg) begin
      hold_cnt  <= '0;
      out_valid <= 1'b0;
    end else if (trig_hi && meas_ok) begin
      if (hold_cnt == HW'(HOLD_MIN)) out_valid <= 1'b1;
      else                           hold_cnt  <= hold_cnt + 1'b1;
    end else if (!trig_hi) begin
      hold_cnt <= '0;
    end
  end

  assign sync_clk   = lvl.sync;
  assign sync_clk_n = ~lvl.sync;
  assign div2_clk   = lvl.div2;
  assign div2_clk_n = ~lvl.div2;
  assign pulse_out  = lvl.pulse;
  assign cont_clk   = lvl.cont;

  // R8: valid is never shown without a settled measurement
  a_r8_valid_needs_meas: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> meas_ok);

  // R8: valid only comes up during a filtered trigger high
  a_r8_valid_rise_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(trig_hi));

  // R8: a detected period change drops valid on the next edge
  a_r8_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
    per_chg |=> !out_valid);

endmodule

// File: tb/sim_trig_clk_regen.sv
`timescale 1ns/1ps
module sim_trig_clk_regen;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic trig_in = 1'b0;
  logic sync_clk, sync_clk_n, div2_clk, div2_clk_n, pulse_out, cont_clk, out_valid;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  int ref_h = 8;
  int ref_l = 8;

  // Edges seen from the trigger drop to the first high clock level, beyond L
  localparam int LAT = 5;

  // {high ticks, low ticks, expect valid drop, inject glitch}
  localparam int unsigned TBL [0:4][0:3] = '{
    '{8,  8,  0, 1},
    '{5,  11, 0, 0},
    '{12, 4,  0, 1},
    '{3,  3,  1, 0},
    '{20, 13, 1, 1}
  };

  always #4 clk = ~clk;

  trig_clk_regen u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_in     (ref_in),
    .trig_in    (trig_in),
    .sync_clk   (sync_clk),
    .sync_clk_n (sync_clk_n),
    .div2_clk   (div2_clk),
    .div2_clk_n (div2_clk_n),
    .pulse_out  (pulse_out),
    .cont_clk   (cont_clk),
    .out_valid  (out_valid)
  );

  // Reference source: new shape applied at the start of a full cycle only
  initial begin
    int h;
    int l;
    #3;
    forever begin
      h = ref_h;
      l = ref_l;
      ref_in = 1'b1;
      #(h * 8);
      ref_in = 1'b0;
      #(l * 8);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input int h, input int l, input int drop, input int glitch);
    int p, seen, k, cs, cd, cp, cm, cc;
    p = h + l;
    @(negedge clk);
    trig_in = 1'b1;
    repeat (40) @(negedge clk);
    ref_h = h;
    ref_l = l;
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!out_valid) seen = 1;
    end
    chk("R8 valid drop on period change", seen, drop);
    repeat (6 * p + 40) @(negedge clk);
    chk("R8 valid after hold", int'(out_valid), 1);
    chk("R2 held levels while trigger high",
        int'({sync_clk, sync_clk_n, div2_clk, div2_clk_n, pulse_out}), 5'b01010);
    cc = 0;
    for (int i = 0; i < 4 * p; i++) begin
      @(negedge clk);
      cc += int'(cont_clk);
    end
    chk("R6 cont carries reference", cc, 4 * h);

    // Trigger fall: count edges to the first high level
    trig_in = 1'b0;
    k = 0;
    cd = 0;
    while (k < 400) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (sync_clk) break;
      cd += int'(div2_clk) + int'(pulse_out);
    end
    chk("R1 first rise latency", k, l + LAT);
    chk("R4 divided clock low before first rise", cd, 0);

    cs = 0; cd = 0; cp = 0; cm = 0; cc = 0;
    for (int i = 0; i < 4 * p; i++) begin
      cs += int'(sync_clk);
      cd += int'(div2_clk);
      cp += int'(pulse_out);
      if (sync_clk_n == sync_clk || div2_clk_n == div2_clk) cm++;
      if (cont_clk != sync_clk) cc++;
      @(negedge clk);
    end
    chk("R3 sync high ticks over four periods", cs, 4 * h);
    chk("R4 divided clock high ticks", cd, 2 * p);
    chk("R5 pulse width two periods", cp, 2 * p);
    chk("R3 complement mismatches", cm, 0);
    chk("R6 cont equals sync while low", cc, 0);

    if (glitch != 0) begin
      trig_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      trig_in = 1'b0;
      repeat (6) @(negedge clk);
    end
    cp = 0; cs = 0;
    for (int i = 0; i < 4 * p; i++) begin
      cp += int'(pulse_out);
      cs += int'(sync_clk);
      @(negedge clk);
    end
    chk("R5 pulse stays low after its two periods", cp, 0);
    if (glitch != 0) chk("R7 short high ignored, clock keeps running", cs, 4 * h);
  endtask

  initial begin
    rst_n   = 1'b0;
    trig_in = 1'b0;
    repeat (5) @(negedge clk);
    chk("R2 levels in reset",
        int'({sync_clk, sync_clk_n, div2_clk, div2_clk_n, pulse_out}), 5'b01010);
    chk("R8 valid low in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    chk("R8 valid low before any trigger high", int'(out_valid), 0);
    chk("R2 levels before any trigger high",
        int'({sync_clk, sync_clk_n, div2_clk, div2_clk_n, pulse_out, cont_clk}), 6'b010100);

    for (int v = 0; v < 5; v++) begin
      run_vec(int'(TBL[v][0]), int'(TBL[v][1]), int'(TBL[v][2]), int'(TBL[v][3]));
    end

    @(negedge clk);
    trig_in = 1'b1;
    repeat (40) @(negedge clk);
    chk("R2 held levels at end",
        int'({sync_clk, sync_clk_n, div2_clk, div2_clk_n, pulse_out}), 5'b01010);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule